// File: doc/BRIEF.md
# Multi-Line Diagnostic Sample Recorder

This block records internal signals of a signal-processing design into an external word-wide memory for later inspection. Four independent capture lines run side by side. Each line picks one of 28 internal 16-bit signals and decimates it by its own integer factor of the master clock. It then streams the kept samples into a single shared write port. Reading the memory back and driving the memory's pins are handled elsewhere.

Software programs a source, a decimation factor and a sample count for a line, then pulses that line's arm input. A shared trigger starts every armed line at once. Each line stores samples until it reaches its count and then raises its done flag.

The memory is split into four equal regions, one per line. The top address bits carry the line number. In wide mode only line 0 may run, and it may fill the whole memory. A two-entry queue per line together with a rotating arbiter lets all four lines run loss-free when every decimation factor is 4 or more.

Top module: `diag_recorder`

## Requirements
- R1: After reset every done flag is low and the memory write enable is low.
- R2: A line stores the 16-bit word of the source its select value names (0 to 27). Select values of 28 and above store the word 0.
- R3: If the trigger is high in the cycle numbered T, a line with decimation d stores as its sample j (j counting from 0) the source value present in cycle T + d·(j+1). A programmed decimation of 0 acts as 1.
- R4: A trigger reaches only lines in the armed state. A trigger given to a line that was never armed causes no memory write and leaves its done flag low.
- R5: A line stores exactly as many samples as its length, at consecutive offsets from 0. The length is clamped to the region size 2^(ADDR_W-2). A length of 0 completes with no write.
- R6: Outside wide mode, line l writes address {l, offset}: the two most significant address bits equal the line number.
- R7: Done rises once the last sample of a line has been handed to the memory port. It then stays high, and further triggers cause no writes until that line is armed again. Arming clears done.
- R8: With all four lines running at decimation 4 or more, no sample is lost, and each memory write slot serves at most one line.
- R9: In wide mode line 0 addresses the whole memory with lengths up to 2^ADDR_W, and arm pulses to lines 1 to 3 are ignored.
- R10: Select, decimation and length are captured when the line is armed. Later changes to them do not alter the running capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_bus | input | NUM_SRC*DATA_W | Internal signals; source k occupies bits k*DATA_W upward |
| sel_cfg | input | NUM_LINES*SEL_W | Source select per line |
| div_cfg | input | NUM_LINES*DIV_W | Decimation factor per line |
| len_cfg | input | NUM_LINES*(ADDR_W+1) | Sample count per line |
| wide_mode | input | 1 | Give the whole memory to line 0 |
| arm | input | NUM_LINES | Per-line arm pulse; latches that line's settings |
| trig | input | 1 | Shared start pulse for armed lines |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| done | output | NUM_LINES | Per-line capture complete flag |

## Verification
The bench builds the recorder with ADDR_W = 8 and DIV_W = 4. This gives 64-word regions and a 256-word memory. With these values the length clamp, a capture in wide mode that crosses the region boundaries, and decimation factors up to 15 all finish within a few hundred cycles. Each source word carries its own index and the low bits of a cycle counter. This makes every stored word show both which source was picked and the exact cycle in which it was sampled.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    L_IDLE   = 2'd0,
    L_ARMED  = 2'd1,
    L_ACTIVE = 2'd2,
    L_DONE   = 2'd3
  } line_state_e;
endpackage

// File: rtl/acq_fifo2.sv
module acq_fifo2 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0] slot_q [2];
  logic [W-1:0] slot_d [2];
  logic         rd_q, rd_d, wr_q, wr_d;
  logic [1:0]   cnt_q, cnt_d;
  logic         do_push, do_pop;

  assign empty = (cnt_q == 2'd0);
  assign full  = (cnt_q == 2'd2);
  assign dout  = slot_q[rd_q];

  always_comb begin
    do_push = push && (!full || pop);
    do_pop  = pop && !empty;
    slot_d  = slot_q;
    rd_d    = rd_q;
    wr_d    = wr_q;
    cnt_d   = cnt_q;
    if (clr) begin
      rd_d  = 1'b0;
      wr_d  = 1'b0;
      cnt_d = 2'd0;
    end else begin
      if (do_push) begin
        slot_d[wr_q] = din;
        wr_d         = ~wr_q;
      end
      if (do_pop) rd_d = ~rd_q;
      cnt_d = cnt_q + {1'b0, do_push} - {1'b0, do_pop};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q[0] <= '0;
      slot_q[1] <= '0;
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      cnt_q     <= 2'd0;
    end else begin
      slot_q <= slot_d;
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      cnt_q  <= cnt_d;
    end
  end

  // R8
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr) |-> !empty);
endmodule

// File: rtl/acq_rr_arb.sv
module acq_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] last_q, last_d;
  logic             found;

  always_comb begin
    grant  = '0;
    found  = 1'b0;
    last_d = last_q;
    for (int off = 1; off <= N; off++) begin
      int idx;
      idx = (int'(last_q) + off) % N;
      if (!found && req[idx]) begin
        grant[idx] = 1'b1;
        found      = 1'b1;
        last_d     = IDX_W'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IDX_W'(N - 1);
    else        last_q <= last_d;
  end

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R8
  grant_fair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|req) |-> (|grant)));
endmodule

// File: rtl/acq_line.sv
module acq_line
  import acq_pkg::*;
#(
  parameter int LINE_IDX  = 0,
  parameter int NUM_LINES = 4,
  parameter int NUM_SRC   = 28,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 20,
  parameter int DIV_W     = 8,
  parameter int SEL_W     = 5,
  localparam int LEN_W    = ADDR_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC*DATA_W-1:0] src_bus,
  input  logic [SEL_W-1:0]          sel_in,
  input  logic [DIV_W-1:0]          div_in,
  input  logic [LEN_W-1:0]          len_in,
  input  logic                      wide,
  input  logic                      arm,
  input  logic                      trig,
  input  logic                      pop,
  output logic                      req,
  output logic [ADDR_W-1:0]         wr_addr,
  output logic [DATA_W-1:0]         wr_data,
  output logic                      done
);
  localparam int IDX_W    = $clog2(NUM_LINES);
  localparam int REGION_W = ADDR_W - IDX_W;
  localparam logic [LEN_W-1:0] REGION_MAX = LEN_W'(1) << REGION_W;
  localparam logic [LEN_W-1:0] FULL_MAX   = LEN_W'(1) << ADDR_W;
  localparam logic [IDX_W-1:0] IDX        = IDX_W'(LINE_IDX);

  line_state_e        state_q, state_d;
  logic               wide_q, wide_d;
  logic [SEL_W-1:0]   sel_q, sel_d;
  logic [DIV_W-1:0]   div_q, div_d;
  logic [LEN_W-1:0]   len_q, len_d;
  logic [DIV_W-1:0]   phase_q, phase_d;
  logic [LEN_W-1:0]   cap_q, cap_d;
  logic [ADDR_W-1:0]  ptr_q, ptr_d;
  logic [LEN_W-1:0]   lim;
  logic               tick, fifo_clr, fifo_empty, fifo_full;
  logic [DATA_W-1:0]  sample;
  logic [DATA_W-1:0]  src_arr [NUM_SRC];

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign src_arr[k] = src_bus[k*DATA_W +: DATA_W];
  end

  always_comb begin
    sample = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (sel_q == SEL_W'(k)) sample = src_arr[k];
    end
  end

  assign tick = (state_q == L_ACTIVE) && (phase_q == div_q - DIV_W'(1));
  assign lim  = wide ? FULL_MAX : REGION_MAX;

  always_comb begin
    state_d  = state_q;
    wide_d   = wide_q;
    sel_d    = sel_q;
    div_d    = div_q;
    len_d    = len_q;
    phase_d  = phase_q;
    cap_d    = cap_q;
    ptr_d    = ptr_q;
    fifo_clr = 1'b0;
    if (arm) begin
      state_d  = L_ARMED;
      wide_d   = wide;
      sel_d    = sel_in;
      div_d    = (div_in == '0) ? DIV_W'(1) : div_in;
      len_d    = (len_in > lim) ? lim : len_in;
      phase_d  = '0;
      cap_d    = '0;
      ptr_d    = '0;
      fifo_clr = 1'b1;
    end else begin
      case (state_q)
        L_ARMED: begin
          if (trig) begin
            state_d = (len_q == '0) ? L_DONE : L_ACTIVE;
            phase_d = '0;
          end
        end
        L_ACTIVE: begin
          if (tick) begin
            phase_d = '0;
            cap_d   = cap_q + LEN_W'(1);
            if (cap_q + LEN_W'(1) == len_q) state_d = L_DONE;
          end else begin
            phase_d = phase_q + DIV_W'(1);
          end
        end
        default: ;
      endcase
      if (pop) ptr_d = ptr_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= L_IDLE;
      wide_q  <= 1'b0;
      sel_q   <= '0;
      div_q   <= DIV_W'(1);
      len_q   <= '0;
      phase_q <= '0;
      cap_q   <= '0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      wide_q  <= wide_d;
      sel_q   <= sel_d;
      div_q   <= div_d;
      len_q   <= len_d;
      phase_q <= phase_d;
      cap_q   <= cap_d;
      ptr_q   <= ptr_d;
    end
  end

  acq_fifo2 #(.W(DATA_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fifo_clr),
    .push  (tick),
    .din   (sample),
    .pop   (pop),
    .dout  (wr_data),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  assign req     = !fifo_empty;
  assign wr_addr = wide_q ? ptr_q : {IDX, ptr_q[REGION_W-1:0]};
  assign done    = (state_q == L_DONE) && fifo_empty;

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !arm) |-> (!fifo_full || pop));
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);
  // R5
  cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q <= len_q);
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == L_IDLE && !arm) |=> (state_q == L_IDLE));
endmodule

// File: rtl/diag_recorder.sv
module diag_recorder #(
  parameter int NUM_LINES = 4,
  parameter int NUM_SRC   = 28,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 20,
  parameter int DIV_W     = 8,
  parameter int SEL_W     = 5,
  localparam int LEN_W    = ADDR_W + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SRC*DATA_W-1:0]   src_bus,
  input  logic [NUM_LINES*SEL_W-1:0]  sel_cfg,
  input  logic [NUM_LINES*DIV_W-1:0]  div_cfg,
  input  logic [NUM_LINES*LEN_W-1:0]  len_cfg,
  input  logic                        wide_mode,
  input  logic [NUM_LINES-1:0]        arm,
  input  logic                        trig,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [DATA_W-1:0]           mem_data,
  output logic                        mem_we,
  output logic [NUM_LINES-1:0]        done
);
  logic [NUM_LINES-1:0] req, grant, arm_eff;
  logic [ADDR_W-1:0]    ln_addr [NUM_LINES];
  logic [DATA_W-1:0]    ln_data [NUM_LINES];
  logic [ADDR_W-1:0]    addr_d;
  logic [DATA_W-1:0]    data_d;
  logic                 we_d;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic ln_wide;
    if (l == 0) begin : g_first
      assign arm_eff[l] = arm[l];
      assign ln_wide    = wide_mode;
    end else begin : g_rest
      assign arm_eff[l] = arm[l] && !wide_mode;
      assign ln_wide    = 1'b0;
    end

    acq_line #(
      .LINE_IDX  (l),
      .NUM_LINES (NUM_LINES),
      .NUM_SRC   (NUM_SRC),
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .DIV_W     (DIV_W),
      .SEL_W     (SEL_W)
    ) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_bus (src_bus),
      .sel_in  (sel_cfg[l*SEL_W +: SEL_W]),
      .div_in  (div_cfg[l*DIV_W +: DIV_W]),
      .len_in  (len_cfg[l*LEN_W +: LEN_W]),
      .wide    (ln_wide),
      .arm     (arm_eff[l]),
      .trig    (trig),
      .pop     (grant[l]),
      .req     (req[l]),
      .wr_addr (ln_addr[l]),
      .wr_data (ln_data[l]),
      .done    (done[l])
    );
  end

  acq_rr_arb #(.N(NUM_LINES)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .grant (grant)
  );

  always_comb begin
    we_d   = |grant;
    addr_d = '0;
    data_d = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      if (grant[l]) begin
        addr_d = addr_d | ln_addr[l];
        data_d = data_d | ln_data[l];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      mem_we <= we_d;
      if (we_d) begin
        mem_addr <= addr_d;
        mem_data <= data_d;
      end
    end
  end

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&done) |=> !mem_we);
endmodule

// File: tb/sim_diag_recorder.sv
module sim_diag_recorder;
  localparam int NL = 4, NS = 28, DW = 16, AW = 8, DV = 4, SW = 5;
  localparam int LW = AW + 1;
  localparam int REG = 64;

  typedef struct packed {
    logic [1:0] line;
    logic [4:0] sel;
    logic [3:0] div;
    logic [8:0] len;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'd0, 5'd3,  4'd1,  9'd10},
    '{2'd1, 5'd27, 4'd3,  9'd5},
    '{2'd2, 5'd30, 4'd2,  9'd4},
    '{2'd3, 5'd12, 4'd0,  9'd6},
    '{2'd1, 5'd0,  4'd15, 9'd3},
    '{2'd2, 5'd5,  4'd1,  9'd100},
    '{2'd3, 5'd28, 4'd1,  9'd0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [NS*DW-1:0] src_bus;
  logic [NL*SW-1:0] sel_cfg;
  logic [NL*DV-1:0] div_cfg;
  logic [NL*LW-1:0] len_cfg;
  logic wide_mode, trig;
  logic [NL-1:0] arm, done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic mem_we;

  logic [SW-1:0] b_sel [NL];
  logic [DV-1:0] b_div [NL];
  logic [LW-1:0] b_len [NL];
  logic [DW-1:0] mem [1<<AW];
  int cyc = 0;
  int wr_cnt = 0;
  int checks = 0;
  int fails = 0;
  bit ended = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    for (int k = 0; k < NS; k++) src_bus[k*DW +: DW] = {5'(k), cyc[10:0]};
    for (int l = 0; l < NL; l++) begin
      sel_cfg[l*SW +: SW] = b_sel[l];
      div_cfg[l*DV +: DV] = b_div[l];
      len_cfg[l*LW +: LW] = b_len[l];
    end
  end

  always @(posedge clk) if (mem_we) begin
    mem[mem_addr] = mem_data;
    wr_cnt = wr_cnt + 1;
  end

  diag_recorder #(.NUM_LINES(NL), .NUM_SRC(NS), .DATA_W(DW), .ADDR_W(AW),
                  .DIV_W(DV), .SEL_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_bus(src_bus), .sel_cfg(sel_cfg),
    .div_cfg(div_cfg), .len_cfg(len_cfg), .wide_mode(wide_mode), .arm(arm),
    .trig(trig), .mem_addr(mem_addr), .mem_data(mem_data), .mem_we(mem_we),
    .done(done));

  function automatic logic [15:0] expv(int s, int t, int d, int j);
    if (s >= 28) return 16'h0000;
    return {5'(s), 11'(t + d * (j + 1))};
  endfunction

  task automatic check(string req, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_region(string req, int base, int s, int t, int d, int n);
    int bad = -1;
    for (int j = 0; j < n; j++)
      if (bad < 0 && mem[base + j] !== expv(s, t, d, j)) bad = j;
    if (bad < 0) check(req, 1'b1, 0, 0);
    else check(req, 1'b0, int'(mem[base + bad]), int'(expv(s, t, d, bad)));
  endtask

  task automatic wait_done(logic [NL-1:0] mask);
    int n = 0;
    while (((done & mask) != mask) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_sim();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_sim();
  end

  initial begin
    int t;
    rst_n = 1'b0; trig = 1'b0; arm = '0; wide_mode = 1'b0;
    for (int l = 0; l < NL; l++) begin b_sel[l] = '0; b_div[l] = 4'd1; b_len[l] = '0; end
    for (int a = 0; a < (1 << AW); a++) mem[a] = 16'hFFFF;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 done", done == '0, int'(done), 0);
    check("R1 we", mem_we == 1'b0, int'(mem_we), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: trigger with no line armed
    wr_cnt = 0;
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    repeat (20) @(negedge clk);
    check("R4 no writes", wr_cnt == 0, wr_cnt, 0);
    check("R4 done low", done == '0, int'(done), 0);

    // R2 R3 R5 R6: table of single-line captures
    for (int v = 0; v < 7; v++) begin
      int l, s, d, n;
      l = int'(VECS[v].line); s = int'(VECS[v].sel);
      d = (VECS[v].div == 0) ? 1 : int'(VECS[v].div);
      n = (int'(VECS[v].len) > REG) ? REG : int'(VECS[v].len);
      b_sel[l] = VECS[v].sel; b_div[l] = VECS[v].div; b_len[l] = VECS[v].len;
      arm[l] = 1'b1; @(negedge clk); arm = '0;
      check("R7 arm clears done", done[l] == 1'b0, int'(done[l]), 0);
      wr_cnt = 0;
      trig = 1'b1; t = cyc; @(negedge clk); trig = 1'b0;
      wait_done(NL'(1) << l);
      check("R5 count", wr_cnt == n, wr_cnt, n);
      check_region("R2 R3 R6 data", l * REG, s, t, d, n);
    end

    // R7: trigger after done is ignored
    wr_cnt = 0;
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    repeat (30) @(negedge clk);
    check("R7 no rewrite", wr_cnt == 0, wr_cnt, 0);
    check("R7 done held", done == 4'b1111, int'(done), 15);

    // R8 R10: all four lines together, settings changed after arm
    for (int l = 0; l < NL; l++) begin b_sel[l] = SW'(l + 1); b_div[l] = 4'd4; b_len[l] = 9'd8; end
    arm = 4'b1111; @(negedge clk); arm = '0;
    for (int l = 0; l < NL; l++) begin b_sel[l] = 5'd20; b_div[l] = 4'd9; b_len[l] = 9'd2; end
    wr_cnt = 0;
    trig = 1'b1; t = cyc; @(negedge clk); trig = 1'b0;
    wait_done(4'b1111);
    check("R8 total writes", wr_cnt == 32, wr_cnt, 32);
    for (int l = 0; l < NL; l++) check_region("R8 R10 data", l * REG, l + 1, t, 4, 8);

    // R9: wide mode, line 0 spans regions, line 1 arm ignored
    wide_mode = 1'b1;
    b_sel[0] = 5'd7; b_div[0] = 4'd1; b_len[0] = 9'd100;
    arm = 4'b0011; @(negedge clk); arm = '0;
    check("R9 line1 arm ignored", done[1] == 1'b1, int'(done[1]), 1);
    wr_cnt = 0;
    trig = 1'b1; t = cyc; @(negedge clk); trig = 1'b0;
    wait_done(4'b0001);
    check("R9 count", wr_cnt == 100, wr_cnt, 100);
    check_region("R9 data", 0, 7, t, 1, 100);
    wide_mode = 1'b0;

    finish_sim();
  end
endmodule